// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs a 10-bit successive-approximation analog-to-digital conversion using a resistor ladder and a comparator that sit outside the chip. A single-cycle start request turns on the converter power enable. The block then waits briefly for the supplies to come up and converts four multiplexed analog channels one after another. Before each new channel it leaves three settling clocks for the multiplexer and the input amplifier. It drives the ladder bit lines and decides one bit per clock from the comparator's single high/low level. Results leave as a serial bit stream, most significant bit first, with a valid strobe. The stream carries a channel tag that stays correct up to and including the final bit.

The clock timing comes from two cascaded modulo counters. The first counts ten states. While it is at 0, 1 and 2 it only settles, and in states 3 to 9 it decides the upper seven bits. When it wraps, an enable flag passes the stepping to a second, shorter counter, which decides the remaining three bits. When the second counter wraps, the channel ends. A one-cycle clamp pulse then advances the channel counter, and when the last channel is done, power is removed.

Top module: `sar_conv_seq`

## Requirements
- R1: While the power enable is low, a one-cycle high level on the start input makes the power enable high from the next clock edge. At that same edge the ladder code becomes the MSB alone (value 512 with 10 bits), and the channel select becomes 0.
- R2: On the first channel after a start, the MSB stays set for PWR_HOLD+SETTLE+1 cycles (5 by default) before its decision. On later channels it stays set for SETTLE+1 cycles (4).
- R3: At each decision edge, the bit under trial is kept when the comparator input is low (ladder below the input) and cleared when it is high. The next lower bit is set at the same edge. The final code is the largest ladder value that does not exceed the input, which is 1023 for any input at or above full scale.
- R4: Each channel takes SETTLE+N_BITS clocks (13). The first SETTLE of them make no decision. One run takes PWR_HOLD+N_CH*(SETTLE+N_BITS) powered cycles (53).
- R5: The serial data output carries each decided bit, MSB first, in the cycle after its decision. The valid strobe is high in exactly those cycles.
- R6: The clamp output is a one-cycle pulse in the cycle after each channel's last decision. The channel select steps 0, 1, 2, 3 at that same edge, and returns to 0 after the last channel.
- R7: The readout channel tag equals the channel select delayed by one clock, so the LSB of every channel carries that channel's number.
- R8: The clamp edge that ends the fourth channel also drops the power enable and zeroes the ladder code. The block stays idle until the next start.
- R9: A start request while the power enable is high has no effect on the running sequence.
- R10: A synchronous active-low reset forces the idle state: power enable, ladder code, clamp, strobe, channel select and channel tag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (one bit decision per clock) |
| rst_n | input | 1 | Synchronous active-low reset |
| go_i | input | 1 | Start request, honoured only while idle |
| cmp_hi_i | input | 1 | Comparator level: high when the ladder exceeds the input |
| pwr_en_o | output | 1 | Converter power enable |
| dac_o | output | N_BITS | Ladder bit lines |
| mux_sel_o | output | CH_W | Analog multiplexer channel select |
| clamp_o | output | 1 | One-cycle channel-advance pulse |
| sdata_o | output | 1 | Serial result bit |
| sval_o | output | 1 | Serial output strobe |
| rd_ch_o | output | CH_W | Channel tag aligned with the serial data |

## Verification
The bench builds the block with its defaults: 10 bits, four channels, ten-state first counter, three settling clocks and a one-cycle power-up hold. These values bring both counter hand-overs within reach, as well as the short second counter, the wrap of the channel counter and the extended first-channel MSB hold. An ideal behavioural ladder and comparator let the input voltages reach zero, full scale, an input above full scale, and the codes that sit on either side of the MSB threshold. Restarts attempted mid-run and a reset mid-channel are also exercised.

// File: rtl/sar_seq_pkg.sv
// Shared types for the conversion sequencer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package sar_seq_pkg;
    // Which of the two cascaded counters is currently advancing.
    typedef enum logic {
        STEP_A = 1'b0,
        STEP_B = 1'b1
    } step_sel_e;
endpackage

// File: rtl/sar_stepper.sv
// Modulo-LEN counter used as a bit-timing stepper.
// Advances once per cycle with adv_i, wraps to zero after LEN-1,
// and reports when it sits on its last state. clr_i wins over adv_i.
// Assumes LEN >= 1.
module sar_stepper #(
    parameter int LEN = 10,
    localparam int W  = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         adv_i,
    output logic [W-1:0] cnt_o,
    output logic         at_last_o
);
    localparam logic [W-1:0] LAST = W'(LEN - 1);

    logic [W-1:0] cnt_q;

    assign at_last_o = (cnt_q == LAST);
    assign cnt_o     = cnt_q;

    // Step, wrap or clear the count.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (clr_i)      cnt_q <= '0;
        else if (adv_i)      cnt_q <= at_last_o ? '0 : cnt_q + W'(1);
    end

    // R4: the count never leaves its LEN states.
    a_r4_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R4: a count on its last state returns to zero when stepped.
    a_r4_step_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i && at_last_o) |=> (cnt_q == '0));
endmodule

// File: rtl/sar_trial_reg.sv
// Successive-approximation trial register with serial result output.
// A one-hot pointer marks the bit under trial. On a decision the
// marked bit is kept or cleared from the comparator, the pointer moves
// one place down and sets the next bit. The decided bit is presented
// serially one cycle later. clear_i beats load_i, which beats the trial
// update. The serial path always takes a decision.
module sar_trial_reg #(
    parameter int N_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              clear_i,
    input  logic              decide_i,
    input  logic              cmp_hi_i,
    output logic [N_BITS-1:0] trial_o,
    output logic              sdata_o,
    output logic              sval_o
);
    localparam logic [N_BITS-1:0] MSB_ONLY = {1'b1, {(N_BITS-1){1'b0}}};

    logic [N_BITS-1:0] trial_q, ptr_q, trial_nxt;
    logic              sdata_q, sval_q;

    // Keep or drop the bit under trial, then raise the next one down.
    always_comb begin
        trial_nxt = (trial_q & ~ptr_q) | (cmp_hi_i ? '0 : ptr_q) | (ptr_q >> 1);
    end

    // Trial code and pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            trial_q <= '0;
            ptr_q   <= '0;
        end else if (load_i) begin
            trial_q <= MSB_ONLY;
            ptr_q   <= MSB_ONLY;
        end else if (decide_i) begin
            trial_q <= trial_nxt;
            ptr_q   <= ptr_q >> 1;
        end
    end

    // Serial result: the decided bit, one clock behind its trial.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sdata_q <= 1'b0;
            sval_q  <= 1'b0;
        end else begin
            sval_q <= decide_i;
            if (decide_i) sdata_q <= !cmp_hi_i;
        end
    end

    assign trial_o = trial_q;
    assign sdata_o = sdata_q;
    assign sval_o  = sval_q;

    // R3: at most one bit is under trial.
    a_r3_ptr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ptr_q));

    // R3: no bit below the trial position is ever set.
    a_r3_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != '0) |-> ((trial_q & (ptr_q - N_BITS'(1))) == '0));

    // R5: a strobe cycle always follows a decision.
    a_r5_strobe_after_decision: assert property (@(posedge clk) disable iff (!rst_n)
        decide_i |=> sval_q);
endmodule

// File: rtl/sar_conv_seq.sv
// Conversion sequencer top.
// A start while idle powers the converter up, holds the MSB for
// PWR_HOLD extra clocks, then converts N_CH channels. Per channel:
// stepper A runs STEP_LEN states (first SETTLE only settle), hands over
// to stepper B for the remaining bits, and B's wrap ends the channel
// with a clamp pulse. Assumes the comparator level is valid at each
// clock edge (settled within one clock) and N_BITS >= STEP_LEN-SETTLE+1.
module sar_conv_seq #(
    parameter int N_BITS   = 10,
    parameter int N_CH     = 4,
    parameter int STEP_LEN = 10,
    parameter int SETTLE   = 3,
    parameter int PWR_HOLD = 1,
    localparam int CH_W    = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              cmp_hi_i,
    output logic              pwr_en_o,
    output logic [N_BITS-1:0] dac_o,
    output logic [CH_W-1:0]   mux_sel_o,
    output logic              clamp_o,
    output logic              sdata_o,
    output logic              sval_o,
    output logic [CH_W-1:0]   rd_ch_o
);
    import sar_seq_pkg::*;

    localparam int B_LEN  = N_BITS - (STEP_LEN - SETTLE);
    localparam int AW     = (STEP_LEN > 1) ? $clog2(STEP_LEN) : 1;
    localparam int BW     = (B_LEN > 1) ? $clog2(B_LEN) : 1;
    localparam int CNT_W  = CH_W + 1;
    localparam int HOLD_W = (PWR_HOLD > 0) ? $clog2(PWR_HOLD + 1) : 1;
    localparam logic [N_BITS-1:0] MSB_ONLY = {1'b1, {(N_BITS-1){1'b0}}};

    logic              active_q;
    logic [HOLD_W-1:0] hold_q;
    step_sel_e         sel_q;
    logic [CNT_W-1:0]  chan_q;
    logic              clamp_q;
    logic [CH_W-1:0]   rdch_q;

    logic [AW-1:0] a_cnt;
    logic [BW-1:0] b_cnt;
    logic          a_last, b_last;
    logic          start, run, adv_a, adv_b, decide, chan_end, last_ch;

    // Control decodes for the current cycle.
    always_comb begin
        start    = go_i && !active_q;
        run      = active_q && (hold_q == '0);
        adv_a    = run && (sel_q == STEP_A);
        adv_b    = run && (sel_q == STEP_B);
        decide   = (adv_a && (a_cnt >= AW'(SETTLE))) || adv_b;
        chan_end = adv_b && b_last;
        last_ch  = (chan_q == CNT_W'(N_CH - 1));
    end

    sar_stepper #(.LEN(STEP_LEN)) u_step_a (
        .clk(clk), .rst_n(rst_n), .clr_i(start), .adv_i(adv_a),
        .cnt_o(a_cnt), .at_last_o(a_last)
    );

    sar_stepper #(.LEN(B_LEN)) u_step_b (
        .clk(clk), .rst_n(rst_n), .clr_i(start), .adv_i(adv_b),
        .cnt_o(b_cnt), .at_last_o(b_last)
    );

    sar_trial_reg #(.N_BITS(N_BITS)) u_trial (
        .clk(clk), .rst_n(rst_n),
        .load_i(start || (chan_end && !last_ch)),
        .clear_i(chan_end && last_ch),
        .decide_i(decide), .cmp_hi_i(cmp_hi_i),
        .trial_o(dac_o), .sdata_o(sdata_o), .sval_o(sval_o)
    );

    // Power state: on at start, off after the final channel.
    always_ff @(posedge clk) begin
        if (!rst_n)                     active_q <= 1'b0;
        else if (start)                 active_q <= 1'b1;
        else if (chan_end && last_ch)   active_q <= 1'b0;
    end

    // Power-up hold countdown before stepping begins.
    always_ff @(posedge clk) begin
        if (!rst_n)                           hold_q <= '0;
        else if (start)                       hold_q <= HOLD_W'(PWR_HOLD);
        else if (active_q && hold_q != '0)    hold_q <= hold_q - HOLD_W'(1);
    end

    // Stepping hand-over between the two counters.
    always_ff @(posedge clk) begin
        if (!rst_n || start)         sel_q <= STEP_A;
        else if (adv_a && a_last)    sel_q <= STEP_B;
        else if (chan_end)           sel_q <= STEP_A;
    end

    // Channel counter, clamp pulse and delayed channel tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q  <= '0;
            clamp_q <= 1'b0;
            rdch_q  <= '0;
        end else begin
            clamp_q <= chan_end;
            rdch_q  <= chan_q[CH_W-1:0];
            if (start)          chan_q <= '0;
            else if (chan_end)  chan_q <= chan_q + CNT_W'(1);
        end
    end

    assign pwr_en_o  = active_q;
    assign mux_sel_o = chan_q[CH_W-1:0];
    assign clamp_o   = clamp_q;
    assign rd_ch_o   = rdch_q;

    // R1/R2: a new run opens with the MSB alone on the ladder.
    a_r2_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en_o) |-> (dac_o == MSB_ONLY));

    // R8: the ladder is dark whenever power is off.
    a_r8_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en_o |-> (dac_o == '0));

    // R6: clamp is a single-cycle pulse.
    a_r6_clamp_single: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_o |=> !clamp_o);

    // R6: each clamp coincides with a channel change.
    a_r6_clamp_moves_mux: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_o |-> (mux_sel_o != $past(mux_sel_o)));

    // R7: channel tag lags the select by one clock.
    a_r7_tag_lags: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ch_o == $past(mux_sel_o)));

    // R9: a start while powered leaves the channel counter alone.
    a_r9_go_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en_o && go_i && !clamp_o && !chan_end) |=> $stable(mux_sel_o));
endmodule

// File: tb/sar_conv_seq_tb_top.sv
// Bench: ideal ladder/comparator, behavioural cycle model, per-clock compare.
module sar_conv_seq_tb_top;
    localparam int NB = 10, NCH = 4, SL = 10, ST = 3, PH = 1;
    localparam int T_LAST = ST + NB - 1;
    localparam int FULL   = (1 << NB) - 1;
    localparam int WD_MAX = 20000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, go = 1'b0, cmp_hi;
    logic pwr_en, clamp, sdata, sval;
    logic [NB-1:0] dac;
    logic [1:0] mux, rdch;

    int vin [NCH];

    // Ideal comparator: high when the ladder exceeds the channel input.
    always_comb cmp_hi = (int'(dac) > vin[mux]);

    sar_conv_seq #(.N_BITS(NB), .N_CH(NCH), .STEP_LEN(SL), .SETTLE(ST), .PWR_HOLD(PH)) dut_i (
        .clk(clk), .rst_n(rst_n), .go_i(go), .cmp_hi_i(cmp_hi),
        .pwr_en_o(pwr_en), .dac_o(dac), .mux_sel_o(mux), .clamp_o(clamp),
        .sdata_o(sdata), .sval_o(sval), .rd_ch_o(rdch)
    );

    int n_tests = 0, n_fail = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Behavioural reference state.
    bit m_act, m_sval, m_clamp, m_sdata;
    int m_hold, m_t, m_ch, m_trial, m_bit, m_mux, m_rdch;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_MAX) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected <%0d cycles", cyc, WD_MAX);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
        if (!rst_n) begin
            m_act = 0; m_sval = 0; m_clamp = 0; m_sdata = 0;
            m_hold = 0; m_t = 0; m_ch = 0; m_trial = 0; m_bit = 0; m_mux = 0; m_rdch = 0;
        end else begin
            m_rdch = m_mux; m_sval = 0; m_clamp = 0;
            if (!m_act) begin
                if (go) begin
                    m_act = 1; m_hold = PH; m_t = 0; m_ch = 0;
                    m_trial = 1 << (NB-1); m_bit = NB-1;
                end
            end else if (m_hold > 0) begin
                m_hold--;
            end else begin
                if (m_t >= ST) begin
                    m_sdata = (m_trial <= vin[m_ch]);
                    m_sval = 1;
                    if (!m_sdata) m_trial -= (1 << m_bit);
                    if (m_bit > 0) begin m_bit--; m_trial += (1 << m_bit); end
                end
                if (m_t == T_LAST) begin
                    m_t = 0; m_clamp = 1; m_ch++;
                    if (m_ch == NCH) begin m_act = 0; m_trial = 0; m_ch = 0; end
                    else begin m_trial = 1 << (NB-1); m_bit = NB-1; end
                end else m_t++;
            end
            m_mux = m_ch;
        end
    end

    // Per-clock comparison against the model, sampled mid-cycle.
    bit cmp_en = 0;
    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk(pwr_en == m_act,   "R1/R8", "pwr_en", int'(pwr_en), int'(m_act));
            chk(int'(dac) == m_trial, "R3", "dac", int'(dac), m_trial);
            chk(int'(mux) == m_mux, "R6", "mux_sel", int'(mux), m_mux);
            chk(clamp == m_clamp,  "R6", "clamp", int'(clamp), int'(m_clamp));
            chk(sval == m_sval,    "R5", "sval", int'(sval), int'(m_sval));
            if (m_sval) chk(sdata == m_sdata, "R5", "sdata", int'(sdata), int'(m_sdata));
            chk(int'(rdch) == m_rdch, "R7", "rd_ch", int'(rdch), m_rdch);
        end
    end

    // Reassemble serial results by channel tag.
    int got [NCH];
    int acc = 0, nbits = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            acc = 0; nbits = 0;
        end else if (sval) begin
            acc = (acc << 1) | int'(sdata);
            nbits++;
            if (nbits == NB) begin
                got[rdch] = acc; acc = 0; nbits = 0;
            end
        end
    end

    task automatic reset_check();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R10: idle state after synchronous reset.
        chk(pwr_en == 1'b0, "R10", "pwr_en", int'(pwr_en), 0);
        chk(dac == '0,      "R10", "dac", int'(dac), 0);
        chk(clamp == 1'b0 && sval == 1'b0, "R10", "clamp|sval", int'(clamp | sval), 0);
        chk(mux == '0 && rdch == '0, "R10", "mux|rd_ch", int'(mux | rdch), 0);
        rst_n = 1'b1;
    endtask

    task automatic run_conv(input int v0, input int v1, input int v2, input int v3, input bit poke_go);
        int pre, total, k;
        bit seen;
        vin[0] = v0; vin[1] = v1; vin[2] = v2; vin[3] = v3;
        for (int i = 0; i < NCH; i++) got[i] = -1;
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
        // R1: powered up with MSB only on channel 0.
        chk(pwr_en == 1'b1, "R1", "pwr_en after go", int'(pwr_en), 1);
        chk(int'(dac) == (1 << (NB-1)), "R1", "dac after go", int'(dac), 1 << (NB-1));
        pre = 0; total = 0; seen = 0; k = 0;
        while (pwr_en) begin
            total++;
            if (!seen && sval) seen = 1;
            else if (!seen) pre++;
            k++;
            go = poke_go && (k == 20 || k == 33);   // R9: restart attempts mid-run
            @(negedge clk);
        end
        go = 1'b0;
        chk(pre == PH + ST + 1, "R2", "first MSB hold cycles", pre, PH + ST + 1);
        chk(total == PH + NCH * (ST + NB), "R4/R9", "powered cycles", total, PH + NCH * (ST + NB));
        repeat (4) @(negedge clk);
        // R8: idle and dark after the fourth channel.
        chk(pwr_en == 1'b0 && dac == '0, "R8", "idle after run", int'(pwr_en) + int'(dac), 0);
        for (int i = 0; i < NCH; i++) begin
            int e;
            e = (vin[i] > FULL) ? FULL : vin[i];
            chk(got[i] == e, "R3", $sformatf("code ch%0d", i), got[i], e);
        end
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) vin[i] = 0;
        repeat (3) @(negedge clk);
        reset_check();
        cmp_en = 1;
        run_conv(0, FULL, 512, 511, 1'b0);
        run_conv(700, 1, 1500, 341, 1'b1);
        // R10: reset during a conversion returns to idle.
        vin[0] = 300;
        @(negedge clk) go = 1'b1;
        @(negedge clk) go = 1'b0;
        repeat (17) @(negedge clk);
        reset_check();
        run_conv(100, 900, 256, 767, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule